// File: doc/BRIEF.md
# Masked Priority Interrupt Arbiter

This block gathers level-sensitive interrupt requests from a set of peripheral sources and decides which of them, if any, is presented to the CPU. Software assigns each source a 4-bit level by writing fields in a small bank of level registers. Software can also block individual sources through a mask that is set and cleared through two separate write-one registers. Each cycle the block picks one winner among the requesting, unblocked sources. It compares the winner's level with the CPU's 4-bit mask input and raises the CPU request only when the winner is strictly above that mask.

The decision is registered, so the CPU request, the reported level and the event code follow the inputs by one clock. After a source has been accepted it stays selected, with a stable event code, for as long as it keeps qualifying. When it stops qualifying, the block arbitrates again in that same cycle among the requests still pending. Losing requests are never dropped: they stay pending until they win or are withdrawn.

Top module: `prio_irq_arb`

## Requirements
- R1: After reset `cpu_irq` is 0, `irq_level` is 0 and `irq_code` is 0. All source levels reset to 0 and all source mask bits reset to 0 (unblocked), so requests from every source are ignored until software programs a level.
- R2: Level register k is written when `wr_addr` equals k, for k = 0 or 1. Source s takes its level from register s/4, bits [4*(s%4)+3 : 4*(s%4)] of `wr_data`.
- R3: Among requesting, unblocked sources, the one with the highest programmed level wins. `irq_level` reports that level.
- R4: If requesting sources share the highest level, the source with the lowest index wins.
- R5: `cpu_irq` is 1 only when the winner's level is strictly greater than `cpu_mask`. A level equal to the mask is not accepted, and a held request is dropped once the mask rises to or above its level.
- R6: A source whose level is 0 is never accepted, whatever the mask value.
- R7: A request that loses arbitration stays pending. When the winner withdraws, the pending request is accepted on the next decision.
- R8: Writing `wr_addr` = 4 sets the mask bit of every source whose `wr_data` bit is 1. A source with its mask bit at 1 takes no part in arbitration. Bits written as 0 leave the mask unchanged.
- R9: Writing `wr_addr` = 5 clears the mask bit of every source whose `wr_data` bit is 1. This is the only way to clear a mask bit: writing 0s to address 4 does not clear one.
- R10: The decision is registered. A request that qualifies in a cycle raises `cpu_irq` after the next rising clock edge, and not before it.
- R11: While `cpu_irq` is 1, `irq_code` equals 0x200 + 0x20 × (source index). It stays on the same source as long as that source keeps requesting, stays unblocked and stays above the mask, even if a higher-level source starts requesting. When `cpu_irq` is 0, `irq_code` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0-1 level registers, 4 mask set, 5 mask clear |
| wr_data | input | 16 | Write data |
| src_req | input | 8 | Level-sensitive request, one bit per source |
| cpu_mask | input | 4 | CPU interrupt mask level |
| cpu_irq | output | 1 | Registered request to the CPU |
| irq_level | output | 4 | Level of the accepted source, 0 when idle |
| irq_code | output | 12 | Event code of the accepted source, 0 when idle |

## Verification
Two things can happen in the same clock edge: a software write to a mask or level register, and the retire-and-rearbitrate decision for the source currently held. The bench provokes this by blocking the held source while a lower-level source is still pending. It then checks that the edge which stores the write still reports the old source, and that the edge after it switches to the pending one. The same one-edge ordering is checked for a mask clear: the unblocked source appears only on the decision that follows the write.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int SRC_N       = 8;
    localparam int LVL_W       = 4;
    localparam int SRC_PER_REG = 4;
    localparam int PRIO_REGS   = (SRC_N + SRC_PER_REG - 1) / SRC_PER_REG;
    localparam int IDX_W       = $clog2(SRC_N);
    localparam int DATA_W      = SRC_PER_REG * LVL_W;
    localparam int ADDR_W      = 3;
    localparam int CODE_W      = 12;

    localparam logic [ADDR_W-1:0] ADDR_MSET = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_MCLR = 3'd5;

    localparam logic [CODE_W-1:0] CODE_BASE = 12'h200;
    localparam logic [CODE_W-1:0] CODE_STEP = 12'h020;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [SRC_N-1:0] vec_t;

    typedef struct packed {
        logic valid;
        idx_t idx;
        lvl_t lvl;
    } win_t;

    // Fixed ordering: higher level first, then lower source index.
    function automatic logic beats(lvl_t a_lvl, idx_t a_idx, lvl_t b_lvl, idx_t b_idx);
        return (a_lvl > b_lvl) || ((a_lvl == b_lvl) && (a_idx < b_idx));
    endfunction

    function automatic logic [CODE_W-1:0] event_code(idx_t i);
        return CODE_BASE + CODE_STEP * CODE_W'(i);
    endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_arb_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [SRC_N*LVL_W-1:0]  lvl_flat,
    output vec_t                    mask_o
);
    logic [DATA_W-1:0] prio_q [PRIO_REGS];
    vec_t              mask_q;
    vec_t              set_bits;
    vec_t              clr_bits;

    for (genvar r = 0; r < PRIO_REGS; r++) begin : g_prio
        always_ff @(posedge clk) begin
            if (rst) begin
                prio_q[r] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(r))) begin
                prio_q[r] <= wr_data;
            end
        end
    end

    for (genvar s = 0; s < SRC_N; s++) begin : g_field
        assign lvl_flat[s*LVL_W +: LVL_W] =
            prio_q[s / SRC_PER_REG][(s % SRC_PER_REG)*LVL_W +: LVL_W];
    end

    assign set_bits = (wr_en && wr_addr == ADDR_MSET) ? wr_data[SRC_N-1:0] : '0;
    assign clr_bits = (wr_en && wr_addr == ADDR_MCLR) ? wr_data[SRC_N-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else begin
            mask_q <= (mask_q | set_bits) & ~clr_bits;
        end
    end

    assign mask_o = mask_q;

    AST_MSET_STICKY: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_MSET) |=>
            ((mask_q & $past(wr_data[SRC_N-1:0])) == $past(wr_data[SRC_N-1:0]))); // R8

    AST_MASK_CLR_ONLY: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == ADDR_MCLR) |=>
            ((mask_q & $past(mask_q)) == $past(mask_q))); // R9
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_arb_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  vec_t                    elig,
    input  logic [SRC_N*LVL_W-1:0]  lvl_flat,
    output win_t                    win
);
    always_comb begin
        win = '0;
        for (int i = 0; i < SRC_N; i++) begin
            if (elig[i] && (!win.valid ||
                beats(lvl_flat[i*LVL_W +: LVL_W], idx_t'(i), win.lvl, win.idx))) begin
                win.valid = 1'b1;
                win.idx   = idx_t'(i);
                win.lvl   = lvl_flat[i*LVL_W +: LVL_W];
            end
        end
    end

    AST_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
        win.valid |-> elig[win.idx]); // R3

    AST_WIN_PRESENT: assert property (@(posedge clk) disable iff (rst)
        (elig != '0) |-> win.valid); // R7

    AST_WIN_LEVEL: assert property (@(posedge clk) disable iff (rst)
        win.valid |-> (win.lvl == lvl_flat[win.idx*LVL_W +: LVL_W])); // R3
endmodule

// File: rtl/irq_accept.sv
module irq_accept
    import irq_arb_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  lvl_t                    cpu_mask,
    input  vec_t                    elig,
    input  logic [SRC_N*LVL_W-1:0]  lvl_flat,
    input  win_t                    win,
    output logic                    busy_o,
    output idx_t                    idx_o,
    output lvl_t                    lvl_o
);
    logic busy_q;
    idx_t idx_q;
    lvl_t lvl_q;
    lvl_t cur_lvl;
    logic held_ok;
    logic take_new;

    assign cur_lvl  = lvl_flat[idx_q*LVL_W +: LVL_W];
    assign held_ok  = busy_q && elig[idx_q] && (cur_lvl > cpu_mask);
    assign take_new = win.valid && (win.lvl > cpu_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            lvl_q  <= '0;
        end else if (held_ok) begin
            lvl_q  <= cur_lvl;
        end else if (take_new) begin
            busy_q <= 1'b1;
            idx_q  <= win.idx;
            lvl_q  <= win.lvl;
        end else begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            lvl_q  <= '0;
        end
    end

    assign busy_o = busy_q;
    assign idx_o  = idx_q;
    assign lvl_o  = lvl_q;

    AST_ABOVE_MASK: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (lvl_q > $past(cpu_mask))); // R5

    AST_LVL_NONZERO: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (lvl_q != '0)); // R6

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && win.valid && win.lvl > cpu_mask) |=> busy_q); // R10

    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (rst)
        (busy_q && elig[idx_q] && cur_lvl > cpu_mask) |=> (busy_q && $stable(idx_q))); // R11
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
    import irq_arb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [SRC_N-1:0]    src_req,
    input  logic [LVL_W-1:0]    cpu_mask,
    output logic                cpu_irq,
    output logic [LVL_W-1:0]    irq_level,
    output logic [CODE_W-1:0]   irq_code
);
    logic [SRC_N*LVL_W-1:0] lvl_flat;
    vec_t                   mask_bits;
    vec_t                   elig;
    win_t                   win;
    logic                   busy;
    idx_t                   idx;
    lvl_t                   lvl;

    irq_cfg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .lvl_flat (lvl_flat),
        .mask_o   (mask_bits)
    );

    assign elig = src_req & ~mask_bits;

    irq_pick u_pick (
        .clk      (clk),
        .rst      (rst),
        .elig     (elig),
        .lvl_flat (lvl_flat),
        .win      (win)
    );

    irq_accept u_accept (
        .clk      (clk),
        .rst      (rst),
        .cpu_mask (cpu_mask),
        .elig     (elig),
        .lvl_flat (lvl_flat),
        .win      (win),
        .busy_o   (busy),
        .idx_o    (idx),
        .lvl_o    (lvl)
    );

    assign cpu_irq   = busy;
    assign irq_level = lvl;
    assign irq_code  = busy ? event_code(idx) : '0;

    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (rst)
        !cpu_irq |-> (irq_code == '0 && irq_level == '0)); // R11

    AST_MASKED_OUT: assert property (@(posedge clk) disable iff (rst)
        (cpu_irq && $past(cpu_irq) && $stable(irq_code)) |-> !$past(mask_bits[idx])); // R8
endmodule

// File: tb/prio_irq_arb_tb_top.sv
module prio_irq_arb_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  src_req = '0;
    logic [3:0]  cpu_mask = '0;
    logic        cpu_irq;
    logic [3:0]  irq_level;
    logic [11:0] irq_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    prio_irq_arb dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .src_req(src_req), .cpu_mask(cpu_mask),
        .cpu_irq(cpu_irq), .irq_level(irq_level), .irq_code(irq_code)
    );

    // Vector fields: {req[19:12], mask[11:8], irq[7], idx[6:4], lvl[3:0]}
    // Levels: s0=3 s1=5 s2=5 s3=1 s4=7 s5=0 s6=2 s7=7
    localparam logic [19:0] VEC [12] = '{
        {8'h02, 4'd0, 1'b1, 3'd1, 4'd5},   // R3
        {8'h06, 4'd0, 1'b1, 3'd1, 4'd5},   // R4 tie
        {8'h90, 4'd0, 1'b1, 3'd4, 4'd7},   // R4 tie
        {8'h0D, 4'd0, 1'b1, 3'd2, 4'd5},   // R3
        {8'h02, 4'd5, 1'b0, 3'd0, 4'd0},   // R5 equal
        {8'h02, 4'd4, 1'b1, 3'd1, 4'd5},   // R5
        {8'h20, 4'd0, 1'b0, 3'd0, 4'd0},   // R6
        {8'h49, 4'd2, 1'b1, 3'd0, 4'd3},   // R3
        {8'h08, 4'd1, 1'b0, 3'd0, 4'd0},   // R5 equal
        {8'hFF, 4'd6, 1'b1, 3'd4, 4'd7},   // R4
        {8'hFF, 4'd7, 1'b0, 3'd0, 4'd0},   // R5
        {8'h41, 4'd0, 1'b1, 3'd0, 4'd3}    // R3
    };

    function automatic logic [11:0] exp_code(logic irq, logic [2:0] idx);
        return irq ? (12'h200 + 12'h020 * {9'd0, idx}) : 12'h000;
    endfunction

    task automatic check(input string tag, input logic irq, input logic [2:0] idx,
                         input logic [3:0] lvl);
        logic [11:0] ec;
        ec = exp_code(irq, idx);
        n_chk++;
        if (cpu_irq !== irq || irq_level !== (irq ? lvl : 4'd0) || irq_code !== ec) begin
            n_bad++;
            $display("FAIL %s: got irq=%0b lvl=%0d code=%h, expected irq=%0b lvl=%0d code=%h",
                     tag, cpu_irq, irq_level, irq_code, irq, irq ? lvl : 4'd0, ec);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic drive(input logic [7:0] r, input logic [3:0] m);
        @(negedge clk);
        src_req = r; cpu_mask = m;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check("R1 reset outputs", 1'b0, 3'd0, 4'd0);
        drive(8'hFF, 4'd0); step();
        check("R1 levels reset to 0", 1'b0, 3'd0, 4'd0);
        drive(8'h00, 4'd0);

        reg_write(3'd0, 16'h1553);   // R2 s3..s0
        reg_write(3'd1, 16'h7207);   // R2 s7..s4

        foreach (VEC[k]) begin
            drive(VEC[k][19:12], VEC[k][11:8]); step();
            check($sformatf("R3/R4/R5/R6 vector %0d", k), VEC[k][7], VEC[k][6:4], VEC[k][3:0]);
            drive(8'h00, 4'd0); step();
        end

        // R10: no change before the edge, result after it
        drive(8'h02, 4'd0); #2;
        check("R10 before edge", 1'b0, 3'd0, 4'd0);
        step();
        check("R10 after edge", 1'b1, 3'd1, 4'd5);
        drive(8'h00, 4'd0); step();

        // R7 pending and R11 hold
        drive(8'h12, 4'd0); step();
        check("R7 winner s4", 1'b1, 3'd4, 4'd7);
        drive(8'h02, 4'd0); step();
        check("R7 pending s1 taken", 1'b1, 3'd1, 4'd5);
        drive(8'h12, 4'd0); step();
        check("R11 no preempt by s4", 1'b1, 3'd1, 4'd5);
        drive(8'h10, 4'd0); step();
        check("R11 retire to s4", 1'b1, 3'd4, 4'd7);

        // R8 same-cycle write vs held decision
        drive(8'h12, 4'd0); step();
        check("R11 s4 held", 1'b1, 3'd4, 4'd7);
        reg_write(3'd4, 16'h0010);
        check("R8 write edge keeps old source", 1'b1, 3'd4, 4'd7);
        step();
        check("R8 masked s4 leaves, s1 taken", 1'b1, 3'd1, 4'd5);

        // R9: zeros to set register do not clear
        reg_write(3'd4, 16'h0000);
        drive(8'h10, 4'd0); step();
        check("R9 s4 still masked", 1'b0, 3'd0, 4'd0);
        reg_write(3'd5, 16'h0010);
        check("R9 clear write edge", 1'b0, 3'd0, 4'd0);
        step();
        check("R9 s4 unmasked", 1'b1, 3'd4, 4'd7);
        drive(8'h00, 4'd0); step();

        // R2 field position: s6 to level 9
        reg_write(3'd1, 16'h7907);
        drive(8'h50, 4'd0); step();
        check("R2 s6 field", 1'b1, 3'd6, 4'd9);
        drive(8'h50, 4'd9); step();
        check("R5 mask rise drops held", 1'b0, 3'd0, 4'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule